// File: doc/BRIEF.md
# Adaptive Vertical Flicker Filter

This block is a vertical low-pass filter for an interlaced video output path. For every output pixel it receives five vertically adjacent samples of luma and five of chroma from an external line store. It forms a weighted sum of them to suppress the flicker that sharp horizontal edges cause between fields. Luma and chroma each have their own 3-bit length select, which picks a 2-, 3-, 4- or 5-line coefficient set. A select whose top bit is set always uses a smoother alternate 5-line set.

When adaptive mode is on, each path decides on every sample whether local vertical contrast is high. Contrast is high when the centre line differs from either neighbouring line by more than a programmable threshold. On such a sample the path swaps its standard set for the alternate set. A return-mode bit chooses how long that swap lasts. With return-mode 0 it lasts until the end of the line. With return-mode 1 it covers only the sample on which contrast was found. A line-start flag on the first beat of each line ends any held swap. A test switch replaces the line-store samples with an internally generated colour-bar pattern, so that the pattern passes through the same filter.

Pixels flow in and out over valid/ready. A beat is taken when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the whole two-stage pipeline stalls, and the output data and flags stay unchanged. Configuration pins are plain levels. They are sampled when a beat is accepted.

Top module: `vflick_filter`

## Requirements
- R1: Line k of a path is bits [8k+7:8k] of `in_y`/`in_c` (k = 0..4, centre line 2). Select code 000 uses weights 4,14,28,14,4 on lines 0..4. Code 001 uses 32,32 on lines 2,3. Code 010 uses 16,32,16 on lines 1..3. Code 011 uses 8,24,24,8 on lines 0..3.
- R2: Luma follows `sel_y` and chroma follows `sel_c` with no coupling, so the two paths can run different lengths on the same beat.
- R3: A select code with bit 2 set always uses the alternate weights 10,12,20,12,10 on lines 0..4, and the path's alternate flag output is 1.
- R4: With `adapt_en` = 0 and a select code with bit 2 clear, the standard set is used and the alternate flag is 0, whatever `ret_mode` and the data are.
- R5: With `adapt_en` = 1, a path detects contrast on a beat when |line2 − line1| > `adapt_thr` or |line2 − line3| > `adapt_thr` (strictly greater). That beat then uses the alternate set.
- R6: With `ret_mode` = 0, once contrast is detected, every later beat of the same line uses the alternate set. A beat with `in_sol` = 1 starts a new line: the held state does not apply to it, but a detection on that beat does.
- R7: With `ret_mode` = 1, the alternate set applies only to the beat on which contrast was detected. The next beat reverts to the standard set.
- R8: The result is (Σ weight·sample + 32) >> 6, limited to the range 0..255.
- R9: With `cbar_en` = 1, all five lines of both paths are replaced by a bar value. The pixel index is 0 on an `in_sol` beat and counts up by one per accepted beat. The bar number is (index >> 2) mod 8. Luma is 235 − 29·bar and chroma is 16 + 32·bar, so the output equals those values.
- R10: A result appears on `out_valid` two clock edges after its beat is accepted, when there is no stall. While `out_valid`=1 and `out_ready`=0, the outputs hold steady and `in_ready` is 0.
- R11: After reset, `out_valid` is 0, `in_ready` is 1, and no held alternate state remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can accept a beat |
| in_sol | input | 1 | Beat is the first pixel of a line |
| in_y | input | 40 | Five luma samples, line k at [8k+7:8k] |
| in_c | input | 40 | Five chroma samples, same packing |
| sel_y | input | 3 | Luma length select |
| sel_c | input | 3 | Chroma length select |
| adapt_en | input | 1 | Enable per-sample adaptive switching |
| ret_mode | input | 1 | 0 hold alternate to end of line, 1 single sample |
| adapt_thr | input | 8 | Contrast threshold |
| cbar_en | input | 1 | Replace input with colour bars |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts output |
| out_y | output | 8 | Filtered luma |
| out_c | output | 8 | Filtered chroma |
| out_alt_y | output | 1 | Luma used the alternate set |
| out_alt_c | output | 1 | Chroma used the alternate set |

## Verification
Some rules are checked on every cycle. While the output is stalled, the data and flags must stay put. `out_valid` may rise only two cycles after an accepted beat. A forced-alternate select must raise the flag, and a path with adaptation off must never show it. The bench scenarios cover everything that depends on arithmetic or on a history of beats. That includes each coefficient set's value, the exact threshold boundary, the held versus single-sample alternate sequences and their clearing at line start, the rounding edge, and the colour-bar values along a line.

// File: rtl/ffv_pkg.sv
package ffv_pkg;
  localparam int NTAP       = 5;
  localparam int CTR_TAP    = 2;
  localparam int COEF_W     = 6;
  localparam int COEF_SHIFT = 6;
  localparam int ROUND_ADD  = 1 << (COEF_SHIFT - 1);
  localparam int BAR_BITS   = 3;

  typedef enum logic [2:0] {
    SET_L5  = 3'd0,
    SET_L2  = 3'd1,
    SET_L3  = 3'd2,
    SET_L4  = 3'd3,
    SET_ALT = 3'd4
  } coef_set_e;

  function automatic coef_set_e decode_len(input logic [2:0] code);
    if (code[2]) return SET_ALT;
    case (code[1:0])
      2'd1:    return SET_L2;
      2'd2:    return SET_L3;
      2'd3:    return SET_L4;
      default: return SET_L5;
    endcase
  endfunction

  // weights of every set sum to 1 << COEF_SHIFT
  function automatic logic [COEF_W-1:0] coef_w(input coef_set_e s, input int idx);
    logic [COEF_W-1:0] w;
    w = '0;
    case (s)
      SET_L5:  case (idx) 0, 4: w = 6'd4;  1, 3: w = 6'd14; 2: w = 6'd28; default: w = '0; endcase
      SET_L2:  case (idx) 2, 3: w = 6'd32; default: w = '0; endcase
      SET_L3:  case (idx) 1, 3: w = 6'd16; 2: w = 6'd32; default: w = '0; endcase
      SET_L4:  case (idx) 0, 3: w = 6'd8;  1, 2: w = 6'd24; default: w = '0; endcase
      SET_ALT: case (idx) 0, 4: w = 6'd10; 1, 3: w = 6'd12; 2: w = 6'd20; default: w = '0; endcase
      default: w = '0;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/ffv_cbar_gen.sv
module ffv_cbar_gen #(
  parameter int DW       = 8,
  parameter int BAR_LOG2 = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          sol,
  output logic [DW-1:0] bar_y,
  output logic [DW-1:0] bar_c
);
  import ffv_pkg::*;
  localparam int CW = BAR_LOG2 + BAR_BITS;

  logic [CW-1:0]       pix_q;
  logic [CW-1:0]       pix_idx;
  logic [BAR_BITS-1:0] bar;

  assign pix_idx = sol ? '0 : pix_q;
  assign bar     = pix_idx[BAR_LOG2 +: BAR_BITS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pix_q <= '0;
    else if (fire) pix_q <= pix_idx + CW'(1);
  end

  always_comb begin
    int ly, lc;
    ly = 235 - 29 * int'(bar);
    lc = 16 + 32 * int'(bar);
    bar_y = DW'(ly) << (DW - 8);
    bar_c = DW'(lc) << (DW - 8);
  end
endmodule

// File: rtl/ffv_adapt.sv
module ffv_adapt #(
  parameter int DW = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          fire,
  input  logic                          sol,
  input  logic [2:0]                    code,
  input  logic                          adapt_en,
  input  logic                          ret_mode,
  input  logic [DW-1:0]                 thr,
  input  logic [ffv_pkg::NTAP*DW-1:0]   taps,
  output ffv_pkg::coef_set_e            set,
  output logic                          use_alt
);
  import ffv_pkg::*;

  logic [DW-1:0] up, ctr, dn, d_up, d_dn;
  logic          detect, sticky_q, hold_ok;

  assign up  = taps[(CTR_TAP-1)*DW +: DW];
  assign ctr = taps[CTR_TAP*DW +: DW];
  assign dn  = taps[(CTR_TAP+1)*DW +: DW];

  assign d_up    = (ctr >= up) ? ctr - up : up - ctr;
  assign d_dn    = (ctr >= dn) ? ctr - dn : dn - ctr;
  assign detect  = (d_up > thr) || (d_dn > thr);
  assign hold_ok = sticky_q && !sol && !ret_mode;

  assign use_alt = code[2] || (adapt_en && (detect || hold_ok));
  assign set     = use_alt ? SET_ALT : decode_len(code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sticky_q <= 1'b0;
    else if (fire) sticky_q <= adapt_en && !ret_mode && !code[2] && use_alt;
  end
endmodule

// File: rtl/ffv_mac.sv
module ffv_mac #(
  parameter int DW = 8
) (
  input  logic [ffv_pkg::NTAP*DW-1:0] taps,
  input  ffv_pkg::coef_set_e          set,
  output logic [DW-1:0]               res
);
  import ffv_pkg::*;
  localparam int ACC_W = DW + COEF_W + 3;
  localparam logic [ACC_W-1:0] MAXV = ACC_W'((1 << DW) - 1);

  logic [ACC_W-1:0] acc, shifted;

  always_comb begin
    acc = '0;
    for (int i = 0; i < NTAP; i++)
      acc = acc + ACC_W'(coef_w(set, i)) * ACC_W'(taps[i*DW +: DW]);
    shifted = (acc + ACC_W'(ROUND_ADD)) >> COEF_SHIFT;
    res = (shifted > MAXV) ? MAXV[DW-1:0] : shifted[DW-1:0];
  end
endmodule

// File: rtl/vflick_filter.sv
module vflick_filter #(
  parameter int DW       = 8,
  parameter int BAR_LOG2 = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic                      in_sol,
  input  logic [ffv_pkg::NTAP*DW-1:0] in_y,
  input  logic [ffv_pkg::NTAP*DW-1:0] in_c,
  input  logic [2:0]                sel_y,
  input  logic [2:0]                sel_c,
  input  logic                      adapt_en,
  input  logic                      ret_mode,
  input  logic [DW-1:0]             adapt_thr,
  input  logic                      cbar_en,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [DW-1:0]             out_y,
  output logic [DW-1:0]             out_c,
  output logic                      out_alt_y,
  output logic                      out_alt_c
);
  import ffv_pkg::*;
  localparam int NPATH = 2;
  localparam int TW    = NTAP * DW;

  logic adv, fire, s1_v, ov_q;
  logic [DW-1:0] bar_y, bar_c;
  logic [NPATH-1:0][TW-1:0] taps_raw, taps_eff, s1_taps;
  logic [NPATH-1:0][2:0]    code;
  logic [NPATH-1:0][DW-1:0] bar_v, mac_res, res_q;
  logic [NPATH-1:0]         alt_now, s1_alt, alt_q;
  coef_set_e                set_now [NPATH];
  coef_set_e                s1_set  [NPATH];

  assign adv      = !ov_q || out_ready;
  assign in_ready = adv;
  assign fire     = in_valid && adv;

  assign taps_raw[0] = in_y;
  assign taps_raw[1] = in_c;
  assign code[0]     = sel_y;
  assign code[1]     = sel_c;
  assign bar_v[0]    = bar_y;
  assign bar_v[1]    = bar_c;

  ffv_cbar_gen #(.DW(DW), .BAR_LOG2(BAR_LOG2)) cbar_i (
    .clk(clk), .rst_n(rst_n), .fire(fire), .sol(in_sol),
    .bar_y(bar_y), .bar_c(bar_c)
  );

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    assign taps_eff[p] = cbar_en ? {NTAP{bar_v[p]}} : taps_raw[p];

    ffv_adapt #(.DW(DW)) adapt_i (
      .clk(clk), .rst_n(rst_n), .fire(fire), .sol(in_sol),
      .code(code[p]), .adapt_en(adapt_en), .ret_mode(ret_mode),
      .thr(adapt_thr), .taps(taps_eff[p]),
      .set(set_now[p]), .use_alt(alt_now[p])
    );

    ffv_mac #(.DW(DW)) mac_i (
      .taps(s1_taps[p]), .set(s1_set[p]), .res(mac_res[p])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_taps[p] <= '0;
        s1_set[p]  <= SET_L5;
        s1_alt[p]  <= 1'b0;
        res_q[p]   <= '0;
        alt_q[p]   <= 1'b0;
      end else if (adv) begin
        s1_taps[p] <= taps_eff[p];
        s1_set[p]  <= set_now[p];
        s1_alt[p]  <= alt_now[p];
        res_q[p]   <= mac_res[p];
        alt_q[p]   <= s1_alt[p];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
      ov_q <= 1'b0;
    end else if (adv) begin
      s1_v <= in_valid;
      ov_q <= s1_v;
    end
  end

  assign out_valid = ov_q;
  assign out_y     = res_q[0];
  assign out_c     = res_q[1];
  assign out_alt_y = alt_q[0];
  assign out_alt_c = alt_q[1];
endmodule

// File: rtl/vflick_filter_chk.sv
module vflick_filter_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [2:0]    sel_y,
  input logic [2:0]    sel_c,
  input logic          adapt_en,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_y,
  input logic [DW-1:0] out_c,
  input logic          out_alt_y,
  input logic          out_alt_c
);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_y) && $stable(out_c)
      && $stable(out_alt_y) && $stable(out_alt_c));

  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready, 2));

  assert_forced_alt_y_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(in_ready) && $past(in_ready, 2) && $past(sel_y[2], 2)
      |-> out_alt_y);

  assert_forced_alt_c_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(in_ready) && $past(in_ready, 2) && $past(sel_c[2], 2)
      |-> out_alt_c);

  assert_noadapt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(in_ready) && $past(in_ready, 2)
      && !$past(adapt_en, 2) && !$past(sel_y[2], 2) |-> !out_alt_y);
endmodule

bind vflick_filter vflick_filter_chk #(.DW(DW)) chk_i (.*);

// File: tb/vflick_filter_tb_top.sv
module vflick_filter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_ready, in_sol = 0;
  logic [39:0] in_y = '0, in_c = '0;
  logic [2:0] sel_y = 0, sel_c = 0;
  logic adapt_en = 0, ret_mode = 0, cbar_en = 0, out_ready = 1;
  logic [7:0] adapt_thr = 8'd10;
  logic out_valid, out_alt_y, out_alt_c;
  logic [7:0] out_y, out_c;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vflick_filter dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sol(in_sol), .in_y(in_y), .in_c(in_c), .sel_y(sel_y), .sel_c(sel_c),
    .adapt_en(adapt_en), .ret_mode(ret_mode), .adapt_thr(adapt_thr),
    .cbar_en(cbar_en), .out_valid(out_valid), .out_ready(out_ready),
    .out_y(out_y), .out_c(out_c), .out_alt_y(out_alt_y), .out_alt_c(out_alt_c)
  );

  function automatic logic [39:0] pk(int a, int b, int c, int d, int e);
    return {8'(e), 8'(d), 8'(c), 8'(b), 8'(a)};
  endfunction

  // weights from R1 / R3; set 4 = alternate
  function automatic int wt(int s, int i);
    int t[5][5] = '{'{4,14,28,14,4}, '{0,0,32,32,0}, '{0,16,32,16,0},
                    '{8,24,24,8,0}, '{10,12,20,12,10}};
    return t[s][i];
  endfunction

  function automatic int model(int s, logic [39:0] v);
    int acc = 0;
    for (int i = 0; i < 5; i++) acc += wt(s, i) * int'(v[8*i +: 8]);
    acc = (acc + 32) >>> 6;
    return (acc > 255) ? 255 : acc;
  endfunction

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // push one beat, wait two edges, check outputs
  task automatic beat(string req, bit sol, logic [39:0] y, logic [39:0] c,
                      int ey, int ec, int ay, int ac);
    @(negedge clk);
    in_valid = 1; in_sol = sol; in_y = y; in_c = c;
    @(negedge clk);
    in_valid = 0; in_sol = 0;
    @(negedge clk);
    check({req, " valid"}, int'(out_valid), 1);
    check({req, " y"}, int'(out_y), ey);
    check({req, " c"}, int'(out_c), ec);
    check({req, " alt_y"}, int'(out_alt_y), ay);
    check({req, " alt_c"}, int'(out_alt_c), ac);
  endtask

  task automatic t_reset();
    check("R11 out_valid", int'(out_valid), 0);
    check("R11 in_ready", int'(in_ready), 1);
  endtask

  task automatic t_lengths();
    logic [39:0] y = pk(10, 50, 200, 90, 30);
    logic [39:0] c = pk(240, 0, 120, 60, 255);
    adapt_en = 0;
    for (int k = 0; k < 4; k++) begin
      sel_y = 3'(k); sel_c = 3'(3 - k);
      beat("R1/R2", 1, y, c, model(k, y), model(3 - k, c), 0, 0);
    end
  endtask

  task automatic t_forced_alt();
    logic [39:0] y = pk(0, 100, 40, 255, 7);
    for (int k = 4; k < 8; k++) begin
      sel_y = 3'(k); sel_c = 3'd0;
      beat("R3", 0, y, y, model(4, y), model(0, y), 1, 0);
    end
  endtask

  task automatic t_noadapt();
    logic [39:0] y = pk(0, 0, 255, 0, 0);
    sel_y = 0; sel_c = 0; adapt_en = 0;
    for (int r = 0; r < 2; r++) begin
      ret_mode = r[0];
      beat("R4", 0, y, y, model(0, y), model(0, y), 0, 0);
    end
  endtask

  task automatic t_threshold();
    logic [39:0] eq = pk(100, 100, 140, 100, 100);
    logic [39:0] ov = pk(100, 100, 141, 100, 100);
    logic [39:0] dn = pk(100, 100, 59, 100, 100);
    logic [39:0] fl = pk(77, 77, 77, 77, 77);
    adapt_en = 1; ret_mode = 1; adapt_thr = 8'd40; sel_y = 0; sel_c = 0;
    beat("R5 equal", 1, eq, fl, model(0, eq), 77, 0, 0);
    beat("R5 above", 0, ov, fl, model(4, ov), 77, 1, 0);
    beat("R5 below", 0, dn, fl, model(4, dn), 77, 1, 0);
  endtask

  task automatic run_seq(string req, bit rm, int exp_flag[5]);
    logic [39:0] q  = pk(100, 100, 100, 100, 100);
    logic [39:0] ld = pk(100, 100, 200, 100, 100);
    adapt_en = 1; ret_mode = rm; adapt_thr = 8'd10; sel_y = 3'd0; sel_c = 3'd0;
    for (int i = 0; i < 5; i++) begin
      logic [39:0] v = (i == 2) ? ld : q;
      beat(req, i == 0, v, q, model(exp_flag[i] ? 4 : 0, v), 100, exp_flag[i], 0);
    end
  endtask

  task automatic t_sticky();
    logic [39:0] q = pk(100, 100, 100, 100, 100);
    logic [39:0] ld = pk(100, 100, 200, 100, 100);
    run_seq("R6 hold", 0, '{0, 0, 1, 1, 1});
    beat("R6 new line clears", 1, q, q, 100, 100, 0, 0);
    beat("R6 stays clear", 0, q, q, 100, 100, 0, 0);
    beat("R6 sol detect", 1, ld, q, model(4, ld), 100, 1, 0);
    beat("R6 sol detect holds", 0, q, q, 100, 100, 1, 0);
  endtask

  task automatic t_return();
    run_seq("R7 single", 1, '{0, 0, 1, 0, 0});
  endtask

  task automatic t_round();
    adapt_en = 0; sel_y = 3'd2; sel_c = 3'd0;
    beat("R8 round down", 1, pk(0, 1, 0, 0, 0), pk(255, 255, 255, 255, 255), 0, 255, 0, 0);
    beat("R8 round up", 0, pk(0, 2, 0, 0, 0), pk(255, 255, 255, 255, 255), 1, 255, 0, 0);
  endtask

  task automatic t_cbar();
    cbar_en = 1; adapt_en = 1; ret_mode = 0; sel_y = 0; sel_c = 3'd1;
    for (int i = 0; i < 36; i++) begin
      int b = (i >> 2) % 8;
      beat("R9", i == 0, pk(1, 2, 3, 4, 5), pk(9, 8, 7, 6, 5),
           235 - 29 * b, 16 + 32 * b, 0, 0);
    end
    cbar_en = 0;
  endtask

  task automatic t_backpressure();
    logic [39:0] a = pk(10, 20, 30, 40, 50);
    logic [39:0] b = pk(200, 150, 100, 50, 0);
    adapt_en = 0; sel_y = 0; sel_c = 0;
    @(negedge clk); @(negedge clk);
    out_ready = 0;
    in_valid = 1; in_sol = 1; in_y = a; in_c = a;
    @(negedge clk);
    check("R10 not yet valid", int'(out_valid), 0);
    in_sol = 0; in_y = b; in_c = b;
    @(negedge clk);
    in_valid = 0;
    check("R10 valid after two edges", int'(out_valid), 1);
    check("R10 first y", int'(out_y), model(0, a));
    check("R10 stall ready", int'(in_ready), 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R10 held valid", int'(out_valid), 1);
      check("R10 held y", int'(out_y), model(0, a));
      check("R10 held c", int'(out_c), model(0, a));
    end
    out_ready = 1;
    @(negedge clk);
    check("R10 second y", int'(out_y), model(0, b));
    check("R10 second valid", int'(out_valid), 1);
    @(negedge clk);
    check("R10 drained", int'(out_valid), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 2 + 1);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_lengths();
    t_forced_alt();
    t_noadapt();
    t_threshold();
    t_sticky();
    t_return();
    t_round();
    t_cbar();
    t_backpressure();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule